// File: doc/BRIEF.md
# Coprocessor Host Bus and Handshake Controller

This block sits between an 8-bit host bus and a command-driven arithmetic coprocessor. It samples chip select, one address line and active-low read and write strobes on the system clock. It turns each falling strobe edge into one of four actions: operand push, operand pop, command entry or status read. Pushes, pops and commands go to the datapath as single-cycle pulses. The datapath reports the end of each command with a `exec_done` pulse and its result flags.

While a command executes, the block stalls the host. If the host tries a push, pop or command, READY drops and the access is parked. The parked access is carried out once the command finishes. Status reads are never stalled.

Completion is signalled on two lines, each with its own acknowledge. The end-of-execution line fires after every command. The service-request line fires only when bit 7 of the command byte asked for it. An active-high reset aborts any work and clears the status, and the block then spends a fixed settling period ignoring the bus.

Top module: `cop_host_port`

## Requirements
- R1: With `cs_n` low and `a_sel` low, a falling `wr_n` produces one `push_valid` pulse carrying the written byte. A falling `rd_n` produces one `pop_req` pulse, and the byte on `pop_data` at that moment is presented on `dout` for the rest of the read. With `cs_n` high, strobes do nothing.
- R2: With `cs_n` low and `a_sel` high, a falling `wr_n` enters a command: one `cmd_start` pulse, with the byte held on `cmd_byte`. A read returns the status byte at any time, busy included, without stalling. Status bit 7 is the busy bit and bits 6:0 are the latched flags.
- R3: `dout_oe` is high exactly while `cs_n` and `rd_n` are both low.
- R4: `ready` is high when idle. A push, pop or command attempted while busy drives `ready` low and is held back until the command completes. It is then performed once and `ready` returns high.
- R5: A `exec_done` pulse while busy clears the busy bit, latches `dp_flags` into status bits 6:0, and drives `eoe_n` low, with `eoe_oe` high while it is low.
- R6: `eoe_n` returns high on `eoe_ack_n` low or on any bus access edge. With `eoe_ack_n` held low, each completion gives a low pulse exactly one clock wide.
- R7: At completion, `srq` rises if bit 7 of the executed command byte is 1. It stays low if that bit is 0.
- R8: `srq` is cleared by `srq_ack_n` low and by the entry of the next command.
- R9: While `rst` is high and for 5 clocks after it falls, the busy bit, the status flags, `eoe_n` (held high) and `srq` are cleared, `ready` is low, `dp_abort` is high and bus strobes are ignored.
- R10: A strobe held low for many clocks produces exactly one action, and at most one of push, pop and command starts in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset |
| cs_n | input | 1 | Chip select, active low |
| a_sel | input | 1 | 0 = data stack, 1 = command/status |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| dout_oe | output | 1 | Bus drive enable for `dout` |
| ready | output | 1 | High when the host access may complete |
| eoe_n | output | 1 | End of execution, active low |
| eoe_oe | output | 1 | Drive enable of `eoe_n` (open-drain model) |
| eoe_ack_n | input | 1 | End-of-execution acknowledge, active low |
| srq | output | 1 | Service request |
| srq_ack_n | input | 1 | Service-request acknowledge, active low |
| push_valid | output | 1 | Operand push pulse to datapath |
| push_data | output | 8 | Operand byte for push |
| pop_req | output | 1 | Operand pop pulse to datapath |
| pop_data | input | 8 | Top-of-stack byte from datapath |
| cmd_start | output | 1 | Command start pulse |
| cmd_byte | output | 8 | Current command byte |
| exec_done | input | 1 | Datapath completion pulse |
| dp_flags | input | 7 | Result flags from datapath |
| dp_abort | output | 1 | Datapath clear during reset and settling |

## Verification
Errors in the busy or parked-access state show up within a few clocks. A stuck busy bit appears as status bit 7 on the next status read and as a `ready` that never returns. A lost parked access shows up as a missing push or pop pulse once the stall ends. A stale service bit or a completion latch of the wrong priority becomes visible on `srq` or `eoe_n` in the clock right after `exec_done`. A bad reset counter shows at the `ready` edge, counted from the fall of `rst`.

// File: rtl/cop_host_pkg.sv
package cop_host_pkg;
  localparam int DW = 8;
  localparam int FW = DW - 1;

  typedef enum logic [1:0] {
    ACC_PUSH = 2'd0,
    ACC_POP  = 2'd1,
    ACC_CMD  = 2'd2
  } acc_kind_e;

  // status byte: busy in the top bit, latched flags below it
  function automatic logic [DW-1:0] status_byte(input logic busy, input logic [FW-1:0] flags);
    return {busy, flags};
  endfunction

  // bit of the command byte that asks for a service request
  function automatic logic wants_service(input logic [DW-1:0] cmd);
    return cmd[DW-1];
  endfunction
endpackage

// File: rtl/cop_strobe_decode.sv
module cop_strobe_decode #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          a_sel,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] din,
  output logic          ev_push,
  output logic          ev_pop,
  output logic          ev_cmd,
  output logic          ev_stat,
  output logic          ev_any,
  output logic [DW-1:0] ev_data
);
  logic s_cs_n, s_a, s_rd_n, s_wr_n, p_rd_n, p_wr_n;
  logic [DW-1:0] s_din;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_cs_n <= 1'b1;
      s_a    <= 1'b0;
      s_rd_n <= 1'b1;
      s_wr_n <= 1'b1;
      p_rd_n <= 1'b1;
      p_wr_n <= 1'b1;
      s_din  <= '0;
    end else begin
      s_cs_n <= cs_n;
      s_a    <= a_sel;
      s_rd_n <= rd_n;
      s_wr_n <= wr_n;
      p_rd_n <= s_rd_n;
      p_wr_n <= s_wr_n;
      s_din  <= din;
    end
  end

  logic rd_fall, wr_fall;
  assign rd_fall = !s_cs_n && !s_rd_n && p_rd_n;
  assign wr_fall = !s_cs_n && !s_wr_n && p_wr_n;

  assign ev_push = wr_fall && !s_a;
  assign ev_cmd  = wr_fall &&  s_a;
  assign ev_pop  = rd_fall && !s_a;
  assign ev_stat = rd_fall &&  s_a;
  assign ev_any  = rd_fall || wr_fall;
  assign ev_data = s_din;
endmodule

// File: rtl/cop_access_seq.sv
module cop_access_seq
  import cop_host_pkg::*;
#(
  parameter int DW = 8,
  parameter int FW = DW - 1
) (
  input  logic          clk,
  input  logic          hold,
  input  logic          ev_push,
  input  logic          ev_pop,
  input  logic          ev_cmd,
  input  logic [DW-1:0] ev_data,
  input  logic          exec_done,
  input  logic [FW-1:0] dp_flags,
  input  logic [DW-1:0] pop_data,
  output logic          push_valid,
  output logic [DW-1:0] push_data,
  output logic          pop_req,
  output logic [DW-1:0] rd_byte,
  output logic          cmd_start,
  output logic [DW-1:0] cmd_q,
  output logic          busy,
  output logic          pend_v,
  output logic          blocked,
  output logic          done_evt,
  output logic          cmd_issue,
  output logic [FW-1:0] flags_q
);
  acc_kind_e     pend_kind, new_kind, act_kind;
  logic [DW-1:0] pend_data, act_data;
  logic          req_new, go_pend, go_new, act;

  always_comb begin
    if (ev_cmd)      new_kind = ACC_CMD;
    else if (ev_pop) new_kind = ACC_POP;
    else             new_kind = ACC_PUSH;
  end

  assign req_new   = (ev_push || ev_pop || ev_cmd) && !hold;
  assign done_evt  = exec_done && busy && !hold;
  assign go_pend   = pend_v && !busy;
  assign go_new    = req_new && !busy && !pend_v;
  assign blocked   = req_new && busy && !pend_v;
  assign act       = go_pend || go_new;
  assign act_kind  = go_pend ? pend_kind : new_kind;
  assign act_data  = go_pend ? pend_data : ev_data;
  assign cmd_issue = act && (act_kind == ACC_CMD);

  always_ff @(posedge clk) begin
    if (hold) begin
      push_valid <= 1'b0;
      push_data  <= '0;
      pop_req    <= 1'b0;
      rd_byte    <= '0;
      cmd_start  <= 1'b0;
      cmd_q      <= '0;
      busy       <= 1'b0;
      pend_v     <= 1'b0;
      pend_kind  <= ACC_PUSH;
      pend_data  <= '0;
      flags_q    <= '0;
    end else begin
      push_valid <= 1'b0;
      pop_req    <= 1'b0;
      cmd_start  <= 1'b0;
      if (done_evt) begin
        busy    <= 1'b0;
        flags_q <= dp_flags;
      end
      if (blocked) begin
        pend_v    <= 1'b1;
        pend_kind <= new_kind;
        pend_data <= ev_data;
      end
      if (go_pend) pend_v <= 1'b0;
      if (act) begin
        case (act_kind)
          ACC_PUSH: begin
            push_valid <= 1'b1;
            push_data  <= act_data;
          end
          ACC_POP: begin
            pop_req <= 1'b1;
            rd_byte <= pop_data;
          end
          default: begin
            cmd_start <= 1'b1;
            cmd_q     <= act_data;
            busy      <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/cop_done_flags.sv
module cop_done_flags (
  input  logic clk,
  input  logic hold,
  input  logic done_evt,
  input  logic svc_bit,
  input  logic any_access,
  input  logic cmd_issue,
  input  logic eoe_ack_n,
  input  logic srq_ack_n,
  output logic eoe_q,
  output logic srq_q
);
  always_ff @(posedge clk) begin
    if (hold) begin
      eoe_q <= 1'b0;
      srq_q <= 1'b0;
    end else begin
      // completion has priority over any clearing source in the same cycle
      if (done_evt)                      eoe_q <= 1'b1;
      else if (!eoe_ack_n || any_access) eoe_q <= 1'b0;

      if (done_evt && svc_bit)           srq_q <= 1'b1;
      else if (!srq_ack_n || cmd_issue)  srq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cop_host_port.sv
module cop_host_port
  import cop_host_pkg::*;
#(
  parameter int DW         = 8,
  parameter int RST_CYCLES = 5,
  localparam int FW  = DW - 1,
  localparam int CNW = $clog2(RST_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          a_sel,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          ready,
  output logic          eoe_n,
  output logic          eoe_oe,
  input  logic          eoe_ack_n,
  output logic          srq,
  input  logic          srq_ack_n,
  output logic          push_valid,
  output logic [DW-1:0] push_data,
  output logic          pop_req,
  input  logic [DW-1:0] pop_data,
  output logic          cmd_start,
  output logic [DW-1:0] cmd_byte,
  input  logic          exec_done,
  input  logic [FW-1:0] dp_flags,
  output logic          dp_abort
);
  logic [CNW-1:0] settle_cnt;
  logic           hold;

  always_ff @(posedge clk) begin
    if (rst)                 settle_cnt <= CNW'(RST_CYCLES);
    else if (settle_cnt != 0) settle_cnt <= settle_cnt - 1'b1;
  end
  assign hold = rst || (settle_cnt != 0);

  logic          ev_push, ev_pop, ev_cmd, ev_stat, ev_any;
  logic [DW-1:0] ev_data;

  cop_strobe_decode #(.DW(DW)) dec_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .a_sel(a_sel), .rd_n(rd_n), .wr_n(wr_n),
    .din(din), .ev_push(ev_push), .ev_pop(ev_pop), .ev_cmd(ev_cmd),
    .ev_stat(ev_stat), .ev_any(ev_any), .ev_data(ev_data)
  );

  logic          busy, pend_v, blocked, done_evt, cmd_issue;
  logic [DW-1:0] rd_byte, cmd_q;
  logic [FW-1:0] flags_q;

  cop_access_seq #(.DW(DW), .FW(FW)) seq_i (
    .clk(clk), .hold(hold), .ev_push(ev_push), .ev_pop(ev_pop), .ev_cmd(ev_cmd),
    .ev_data(ev_data), .exec_done(exec_done), .dp_flags(dp_flags), .pop_data(pop_data),
    .push_valid(push_valid), .push_data(push_data), .pop_req(pop_req), .rd_byte(rd_byte),
    .cmd_start(cmd_start), .cmd_q(cmd_q), .busy(busy), .pend_v(pend_v), .blocked(blocked),
    .done_evt(done_evt), .cmd_issue(cmd_issue), .flags_q(flags_q)
  );

  logic svc_bit, any_access, eoe_q, srq_q;
  assign svc_bit    = wants_service(cmd_q);
  assign any_access = ev_any && !hold;

  cop_done_flags flags_i (
    .clk(clk), .hold(hold), .done_evt(done_evt), .svc_bit(svc_bit),
    .any_access(any_access), .cmd_issue(cmd_issue), .eoe_ack_n(eoe_ack_n),
    .srq_ack_n(srq_ack_n), .eoe_q(eoe_q), .srq_q(srq_q)
  );

  assign dout_oe  = !cs_n && !rd_n;
  assign dout     = a_sel ? status_byte(busy, flags_q) : rd_byte;
  assign ready    = !pend_v && !hold;
  assign eoe_n    = !eoe_q;
  assign eoe_oe   = eoe_q;
  assign srq      = srq_q;
  assign cmd_byte = cmd_q;
  assign dp_abort = hold;
endmodule

// File: rtl/cop_host_port_chk.sv
module cop_host_port_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic pend_v,
  input logic blocked,
  input logic done_evt,
  input logic svc_bit,
  input logic ready,
  input logic eoe_n,
  input logic eoe_ack_n,
  input logic srq,
  input logic srq_ack_n,
  input logic push_valid,
  input logic pop_req,
  input logic cmd_start
);
  p_busy_on_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> busy);

  p_stall_r4: assert property (@(posedge clk) disable iff (rst)
    blocked |=> !ready);

  p_parked_low_r4: assert property (@(posedge clk) disable iff (rst)
    (pend_v && busy) |-> !ready);

  p_eoe_set_r5: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> (!eoe_n && !busy));

  p_eoe_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (!eoe_n && !eoe_ack_n && !done_evt) |=> eoe_n);

  p_srq_set_r7: assert property (@(posedge clk) disable iff (rst)
    (done_evt && svc_bit) |=> srq);

  p_srq_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (!srq_ack_n && !done_evt) |=> !srq);

  p_one_action_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({push_valid, pop_req, cmd_start}));

  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;
  always @(negedge clk) begin
    if (rst_seen) begin
      p_reset_clear_r9: assert (!busy && !ready && eoe_n && !srq);
    end
  end
endmodule

bind cop_host_port cop_host_port_chk chk_i (
  .clk(clk), .rst(rst), .busy(busy), .pend_v(pend_v), .blocked(blocked),
  .done_evt(done_evt), .svc_bit(svc_bit), .ready(ready), .eoe_n(eoe_n),
  .eoe_ack_n(eoe_ack_n), .srq(srq), .srq_ack_n(srq_ack_n),
  .push_valid(push_valid), .pop_req(pop_req), .cmd_start(cmd_start)
);

// File: tb/cop_host_port_tb_top.sv
`timescale 1ns/1ps
module cop_host_port_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, a_sel = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_oe, ready, eoe_n, eoe_oe, srq;
  logic eoe_ack_n = 1'b1, srq_ack_n = 1'b1;
  logic push_valid, pop_req, cmd_start, dp_abort;
  logic [7:0] push_data, cmd_byte;
  logic [7:0] pop_data = '0;
  logic exec_done = 1'b0;
  logic [6:0] dp_flags = '0;

  always #2 clk = ~clk;

  cop_host_port dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .a_sel(a_sel), .rd_n(rd_n), .wr_n(wr_n),
    .din(din), .dout(dout), .dout_oe(dout_oe), .ready(ready), .eoe_n(eoe_n),
    .eoe_oe(eoe_oe), .eoe_ack_n(eoe_ack_n), .srq(srq), .srq_ack_n(srq_ack_n),
    .push_valid(push_valid), .push_data(push_data), .pop_req(pop_req),
    .pop_data(pop_data), .cmd_start(cmd_start), .cmd_byte(cmd_byte),
    .exec_done(exec_done), .dp_flags(dp_flags), .dp_abort(dp_abort)
  );

  int n_checks = 0, n_fail = 0;
  int n_push = 0, n_pop = 0, n_cmd = 0, n_eoe_low = 0;
  logic [7:0] last_push = '0, last_cmd = '0;

  always @(negedge clk) begin
    if (push_valid) begin n_push++; last_push = push_data; end
    if (pop_req) n_pop++;
    if (cmd_start) begin n_cmd++; last_cmd = cmd_byte; end
    if (!eoe_n) n_eoe_low++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input logic b, input logic [6:0] f);
    exp_status = 8'(f);
    exp_status[7] = b;
  endfunction

  // one bus access; returns read byte, oe seen and whether it was stalled
  task automatic acc(input bit wr, input bit a, input logic [7:0] d, input int hold_c,
                     output logic [7:0] rv, output logic oe, output bit waited);
    @(negedge clk);
    cs_n = 1'b0; a_sel = a; din = d;
    if (wr) wr_n = 1'b0; else rd_n = 1'b0;
    repeat (hold_c) @(negedge clk);
    waited = 1'b0;
    while (!ready) begin waited = 1'b1; @(negedge clk); end
    rv = dout; oe = dout_oe;
    wr_n = 1'b1; rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic finish_cmd(input logic [6:0] f);
    @(negedge clk);
    exec_done = 1'b1; dp_flags = f;
    @(negedge clk);
    exec_done = 1'b0;
    chk("R5 eoe_n low after done", eoe_n, 0);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rv, d, c;
    logic oe;
    bit w;
    int base;
    void'($urandom(32'h5eed_2024));

    // reset state
    repeat (3) @(negedge clk);
    chk("R9 ready low in reset", ready, 0);
    chk("R9 eoe_n high in reset", eoe_n, 1);
    chk("R9 srq low in reset", srq, 0);
    chk("R9 dp_abort in reset", dp_abort, 1);
    rst = 1'b0;
    @(negedge clk);
    cs_n = 1'b0; a_sel = 1'b0; wr_n = 1'b0; din = 8'hAA;
    @(negedge clk); @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    chk("R9 ready low in settling", ready, 0);
    @(negedge clk);
    chk("R9 ready high after 5 clocks", ready, 1);
    repeat (3) @(negedge clk);
    chk("R9 strobe during settling ignored", n_push, 0);
    acc(0, 1, 0, 3, rv, oe, w);
    chk("R9 status cleared", rv, 8'h00);

    // R3 drive enable
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1;
    @(negedge clk); chk("R3 oe low with rd_n high", dout_oe, 0);
    cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk); chk("R3 oe low with cs_n high", dout_oe, 0);
    wr_n = 1'b0;
    repeat (4) @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 no action with cs_n high", n_push + n_pop, 0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      case ($urandom_range(0, 2))
        0: begin
          base = n_push; d = 8'($urandom);
          acc(1, 0, d, 3, rv, oe, w);
          chk("R1 push count", n_push, base + 1);
          chk("R1 push data", last_push, d);
        end
        1: begin
          base = n_pop; pop_data = 8'($urandom);
          acc(0, 0, 0, 3, rv, oe, w);
          chk("R1 pop byte", rv, pop_data);
          chk("R1 pop count", n_pop, base + 1);
          chk("R3 oe during read", oe, 1);
        end
        default: begin
          logic [6:0] f;
          base = n_cmd; c = 8'($urandom);
          acc(1, 1, c, 3, rv, oe, w);
          chk("R2 cmd count", n_cmd, base + 1);
          chk("R2 cmd byte", last_cmd, c);
          acc(0, 1, 0, 3, rv, oe, w);
          chk("R2 busy status", rv[7], 1);
          chk("R2 status read not stalled", w, 0);
          repeat ($urandom_range(0, 4)) @(negedge clk);
          f = 7'($urandom);
          finish_cmd(f);
          chk("R7 srq follows bit 7", srq, c[7]);
          acc(0, 1, 0, 3, rv, oe, w);
          chk("R5 status after done", rv, exp_status(1'b0, f));
          chk("R6 eoe cleared by access", eoe_n, 1);
          if (srq) begin
            @(negedge clk); srq_ack_n = 1'b0;
            @(negedge clk); srq_ack_n = 1'b1;
            chk("R8 srq cleared by ack", srq, 0);
          end
        end
      endcase
    end

    // R4 stall of a push during execution
    acc(1, 1, 8'h01, 3, rv, oe, w);
    base = n_push;
    fork
      acc(1, 0, 8'h5A, 3, rv, oe, w);
      begin
        repeat (8) @(negedge clk);
        chk("R4 ready low while parked", ready, 0);
        chk("R4 push held back", n_push, base);
        finish_cmd(7'h11);
      end
    join
    chk("R4 parked push done once", n_push, base + 1);
    chk("R4 parked push data", last_push, 8'h5A);
    chk("R4 ready back high", ready, 1);

    // R6 ack pulse clears, then ack held low gives one-clock pulse
    acc(1, 1, 8'h02, 3, rv, oe, w);
    finish_cmd(7'h00);
    @(negedge clk); eoe_ack_n = 1'b0;
    @(negedge clk); eoe_ack_n = 1'b1;
    chk("R6 eoe cleared by ack", eoe_n, 1);
    eoe_ack_n = 1'b0;
    acc(1, 1, 8'h03, 3, rv, oe, w);
    base = n_eoe_low;
    finish_cmd(7'h00);
    repeat (3) @(negedge clk);
    chk("R6 one-clock eoe pulse", n_eoe_low - base, 1);
    eoe_ack_n = 1'b1;

    // R8 srq cleared by next command
    acc(1, 1, 8'h81, 3, rv, oe, w);
    finish_cmd(7'h05);
    chk("R7 srq set", srq, 1);
    acc(1, 1, 8'h04, 3, rv, oe, w);
    chk("R8 srq cleared by next command", srq, 0);
    finish_cmd(7'h00);
    chk("R7 srq stays low for bit7=0", srq, 0);

    // R10 long strobe
    base = n_push;
    acc(1, 0, 8'h3C, 12, rv, oe, w);
    chk("R10 single push for long strobe", n_push, base + 1);

    // R9 reset while busy
    acc(1, 1, 8'h83, 3, rv, oe, w);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    repeat (6) @(negedge clk);
    acc(0, 1, 0, 3, rv, oe, w);
    chk("R9 reset clears busy and flags", rv, 8'h00);
    chk("R9 srq clear after reset", srq, 0);
    chk("R9 eoe high after reset", eoe_n, 1);

    summary();
    $finish;
  end
endmodule